// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a 4096 Hz enable strobe into a 100 Hz tick. The ratio 4096/100 = 40.96 is not an integer, so the divider runs a fixed pattern of 25 output periods. The first 24 periods each span 41 strobes and the last spans 40. Over the pattern that adds up to 1024 strobes, which is exactly a quarter second. The average tick rate is therefore exactly 100 Hz, although single periods jitter by a fraction of an input cycle.

The block runs in one clock domain. It counts only on clocks where the strobe is high, so the strobe may arrive at any spacing. Both outputs are registered single-clock pulses. The quarter-second marker fires together with the tick that closes the short 25th period, and marks the point where the tick is back in phase with the input.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, and after each marker, periods 1 to 24 of the pattern each end on the 41st counted strobe of that period.
- R2: Period 25 of the pattern ends on its 40th counted strobe.
- R3: The tick goes high for exactly one clock: the clock that follows the edge at which the strobe ending a period was sampled. On every other clock it is low.
- R4: The marker is high only together with the tick that ends period 25. That makes one marker every 1024 counted strobes.
- R5: A clock with the strobe low does not advance the count. A gap of any length between strobes leaves the position in the pattern unchanged.
- R6: A synchronous reset clears both counters and both outputs. Counting then restarts at the beginning of period 1.
- R7: Each marker interval holds exactly 25 ticks.
- R8: A strobe that arrives while reset is high is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_4096 | input | 1 | 4096 Hz count-enable strobe |
| tick_100 | output | 1 | One-clock 100 Hz tick (registered) |
| qtr_mark | output | 1 | One-clock quarter-second realignment marker (registered) |

## Verification
The hardest case to reach is the short 25th period, and in particular its final strobe while the strobe spacing is irregular. Getting there takes 1024 counted strobes, and only at that point does a 40-versus-41 mistake show up. The stimulus runs several full quarter-second patterns: one with the strobe high every clock, one with a strobe every third clock, and one with a pseudo-random strobe pattern. Between these runs it applies a reset with strobes present, so the pattern must restart cleanly in the middle of a period.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int DEF_LONG_DIV  = 41;
  localparam int DEF_SHORT_DIV = 40;
  localparam int DEF_PERIODS   = 25;

  function automatic int width_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fdiv_cycle_ctr.sv
module fdiv_cycle_ctr
  import frac_div_pkg::*;
#(
  parameter int LONG_DIV  = DEF_LONG_DIV,
  parameter int SHORT_DIV = DEF_SHORT_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic use_short,
  output logic wrap
);
  localparam int CW = width_for(LONG_DIV);
  localparam logic [CW-1:0] LONG_END  = CW'(LONG_DIV - 1);
  localparam logic [CW-1:0] SHORT_END = CW'(SHORT_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] end_val;

  always_comb begin
    end_val = use_short ? SHORT_END : LONG_END;
    wrap    = en && (cnt_q == end_val);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (wrap)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_q + 1'b1;
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LONG_END);
  a_r5_hold_no_en: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));
  a_r2_short_limit: assert property (@(posedge clk) disable iff (rst)
    use_short |-> cnt_q <= SHORT_END);
endmodule

// File: rtl/fdiv_period_seq.sv
module fdiv_period_seq
  import frac_div_pkg::*;
#(
  parameter int PERIODS = DEF_PERIODS
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic last
);
  localparam int PW = width_for(PERIODS);
  localparam logic [PW-1:0] LAST_IDX = PW'(PERIODS - 1);

  logic [PW-1:0] idx_q;

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (step)
      idx_q <= last ? '0 : idx_q + 1'b1;
  end

  a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);
  a_r5_idx_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx_q));
endmodule

// File: rtl/fdiv_out_reg.sv
module fdiv_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic period_done,
  input  logic seq_done,
  output logic tick_q,
  output logic mark_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      tick_q <= period_done;
      mark_q <= period_done && seq_done;
    end
  end

  a_r4_mark_with_tick: assert property (@(posedge clk) disable iff (rst)
    mark_q |-> tick_q);
  a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> !tick_q && !mark_q);
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_div_pkg::*;
#(
  parameter int LONG_DIV  = DEF_LONG_DIV,
  parameter int SHORT_DIV = DEF_SHORT_DIV,
  parameter int PERIODS   = DEF_PERIODS
) (
  input  logic clk,
  input  logic rst,
  input  logic en_4096,
  output logic tick_100,
  output logic qtr_mark
);
  logic wrap;
  logic last;
  logic en_gated;

  assign en_gated = en_4096 && !rst;

  fdiv_cycle_ctr #(.LONG_DIV(LONG_DIV), .SHORT_DIV(SHORT_DIV)) u_cyc (
    .clk(clk), .rst(rst), .en(en_gated), .use_short(last), .wrap(wrap)
  );

  fdiv_period_seq #(.PERIODS(PERIODS)) u_seq (
    .clk(clk), .rst(rst), .step(wrap), .last(last)
  );

  fdiv_out_reg u_out (
    .clk(clk), .rst(rst), .period_done(wrap), .seq_done(last),
    .tick_q(tick_100), .mark_q(qtr_mark)
  );

  a_r8_reset_blocks: assert property (@(posedge clk)
    rst |=> !tick_100);
endmodule

// File: tb/frac_tick_gen_test.sv
module frac_tick_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_4096 = 1'b0;
  logic tick_100;
  logic qtr_mark;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit    q_tick[$];
  bit    q_mark[$];
  string q_tag[$];

  int m_cyc = 0;
  int m_per = 0;
  int ticks_since_mark = -1;

  always #10 clk = ~clk;

  frac_tick_gen uut (
    .clk(clk), .rst(rst), .en_4096(en_4096),
    .tick_100(tick_100), .qtr_mark(qtr_mark)
  );

  task automatic check(input string tag, input bit act_t, input bit exp_t,
                       input bit act_m, input bit exp_m);
    n_checks++;
    if (act_t !== exp_t || act_m !== exp_m) begin
      n_fail++;
      $display("FAIL %s: tick=%0b mark=%0b expected tick=%0b mark=%0b at %0t",
               tag, act_t, act_m, exp_t, exp_m, $time);
    end
  endtask

  task automatic drive(input bit e, input bit r);
    bit t;
    bit m;
    int lim;
    @(negedge clk);
    en_4096 = e;
    rst = r;
    if (r) begin
      m_cyc = 0;
      m_per = 0;
    end else if (e) begin
      t = 1'b0;
      m = 1'b0;
      lim = (m_per == 24) ? 40 : 41;
      m_cyc++;
      if (m_cyc == lim) begin
        t = 1'b1;
        m_cyc = 0;
        if (m_per == 24) begin
          m = 1'b1;
          m_per = 0;
        end else begin
          m_per++;
        end
      end
      q_tick.push_back(t);
      q_mark.push_back(m);
      if (m) q_tag.push_back("R4");
      else if (t) q_tag.push_back((m_per == 0) ? "R2" : "R1");
      else q_tag.push_back("R3");
    end
  endtask

  always @(posedge clk) begin
    bit s_en;
    bit s_rst;
    bit et;
    bit em;
    string tg;
    s_en = en_4096;
    s_rst = rst;
    #2;
    if (s_rst) begin
      check(s_en ? "R8" : "R6", tick_100, 1'b0, qtr_mark, 1'b0);
      ticks_since_mark = -1;
    end else if (s_en) begin
      if (q_tick.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R3: queue empty, actual tick=%0b expected a queued item", tick_100);
      end else begin
        et = q_tick.pop_front();
        em = q_mark.pop_front();
        tg = q_tag.pop_front();
        check(tg, tick_100, et, qtr_mark, em);
        if (tick_100 && ticks_since_mark >= 0) ticks_since_mark++;
        if (qtr_mark) begin
          if (ticks_since_mark >= 0) begin
            n_checks++;
            if (ticks_since_mark != 25) begin
              n_fail++;
              $display("FAIL R7: ticks in interval=%0d expected 25", ticks_since_mark);
            end
          end
          ticks_since_mark = 0;
        end
      end
    end else begin
      check("R5", tick_100, 1'b0, qtr_mark, 1'b0);
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1);
    // R1 R2 R4: strobe every clock through a full pattern and beyond
    for (int i = 0; i < 1100; i++) drive(1'b1, 1'b0);
    // R5: strobe every third clock
    for (int i = 0; i < 3300; i++) drive(i % 3 == 0, 1'b0);
    // R6 R8: reset with strobes present, mid-period
    for (int i = 0; i < 2; i++) drive(1'b1, 1'b1);
    // R5 R7: pseudo-random strobe pattern
    for (int i = 0; i < 2600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], 1'b0);
    end
    for (int i = 0; i < 2100; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule